// File: doc/BRIEF.md
# Floating-Point Condition Code Generator

A purely combinational unit that turns IEEE 754 binary32 or binary64 values into a two-bit condition code. It is meant to sit after a floating-point datapath or a compare path. It also raises a one-bit invalid-operation indication.

In compare mode the unit orders two operands with quiet semantics. The code then reports:

- equality,
- first operand below the second,
- first operand above the second,
- no ordering, because a NaN is present.

In test mode the unit looks at a single result value and classifies it as zero, negative, positive or NaN. The second operand is then ignored.

A precision select chooses between the two formats. In binary32 mode only the low 32 bits of each 64-bit operand input take part. Whatever the mode, code 3 always means a NaN was involved.

Top module: `fp_cc_gen`

## Requirements
- R1: In compare mode (`test_mode`=0), operands that are equal give `cc`=0; +0 and -0 count as equal.
- R2: In compare mode, non-NaN operands where `opa` is below `opb` give `cc`=1, and `opa` above `opb` gives `cc`=2. This ordering follows sign and magnitude, including infinities and subnormals.
- R3: In compare mode, if either operand is a NaN, `cc`=3. A NaN is an exponent of all ones with a non-zero fraction.
- R4: In compare mode, `invalid`=1 exactly when at least one operand is a signaling NaN, that is, a NaN whose fraction MSB is 0. Quiet NaNs leave `invalid`=0.
- R5: In test mode (`test_mode`=1), an `opa` that is a NaN, whether quiet or signaling, gives `cc`=3.
- R6: In test mode, an `opa` of zero of either sign gives `cc`=0.
- R7: In test mode, a non-zero, non-NaN `opa` gives `cc`=1 when its sign is set and `cc`=2 when its sign is clear. Infinities are included.
- R8: In test mode `invalid` is always 0, and `opb` has no effect on the outputs.
- R9: With `dbl_sel`=0 (binary32: sign in bit 31, exponent in bits 30:23, fraction in bits 22:0), bits 63:32 of both operands have no effect. With `dbl_sel`=1 the binary64 layout is used: sign in bit 63, exponent in bits 62:52, fraction in bits 51:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_mode | input | 1 | 0 = two-operand compare, 1 = one-operand classification |
| dbl_sel | input | 1 | 0 = binary32 in the low half, 1 = binary64 |
| opa | input | 64 | First operand, or the value to classify |
| opb | input | 64 | Second operand (compare mode only) |
| cc | output | 2 | Condition code 0..3 |
| invalid | output | 1 | Invalid operation: signaling NaN seen in compare mode |

## Verification
The block has no parameters, so the bench uses its single fixed build. Both formats and both modes are chosen at run time, so that one build reaches every combination. The vectors pair each precision with each mode. They set garbage in the ignored upper halves and in the unused second operand. They also place signaling and quiet NaNs on either side of a compare, so that the invalid flag is separated from the unordered code.

// File: rtl/fp_cc_gen.sv
module fp_cc_gen (
  input  logic        test_mode,
  input  logic        dbl_sel,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  output logic [1:0]  cc,
  output logic        invalid
);

  localparam int DW   = 64;
  localparam int SW   = 32;
  localparam int DEXP = 11;
  localparam int SEXP = 8;
  localparam int DFR  = DW - 1 - DEXP;
  localparam int SFR  = SW - 1 - SEXP;

  typedef struct packed {
    logic            sign;
    logic            nan;
    logic            snan;
    logic            zero;
    logic [DW-2:0]   mag;
  } fcls_t;

  function automatic fcls_t classify(input logic [DW-1:0] v, input logic dbl);
    fcls_t r;
    logic  e_ones, f_nz, f_msb;
    if (dbl) begin
      r.sign = v[DW-1];
      e_ones = &v[DW-2:DFR];
      f_nz   = |v[DFR-1:0];
      f_msb  = v[DFR-1];
      r.mag  = v[DW-2:0];
    end else begin
      r.sign = v[SW-1];
      e_ones = &v[SW-2:SFR];
      f_nz   = |v[SFR-1:0];
      f_msb  = v[SFR-1];
      r.mag  = {{(DW-SW){1'b0}}, v[SW-2:0]};
    end
    r.nan  = e_ones & f_nz;
    r.snan = r.nan & ~f_msb;
    r.zero = ~|r.mag;
    return r;
  endfunction

  fcls_t ca, cb;
  assign ca = classify(opa, dbl_sel);
  assign cb = classify(opb, dbl_sel);

  logic unord, both_zero, eq, lt;
  assign unord     = ca.nan | cb.nan;
  assign both_zero = ca.zero & cb.zero;
  assign eq        = both_zero | (ca.sign == cb.sign && ca.mag == cb.mag);

  always_comb begin
    if (ca.sign != cb.sign) lt = ca.sign;
    else if (!ca.sign)      lt = ca.mag < cb.mag;
    else                    lt = ca.mag > cb.mag;
  end

  always_comb begin
    if (test_mode) begin
      if (ca.nan)       cc = 2'd3;
      else if (ca.zero) cc = 2'd0;
      else if (ca.sign) cc = 2'd1;
      else              cc = 2'd2;
    end else begin
      if (unord)        cc = 2'd3;
      else if (eq)      cc = 2'd0;
      else if (lt)      cc = 2'd1;
      else              cc = 2'd2;
    end
  end

  assign invalid = ~test_mode & (ca.snan | cb.snan);

endmodule

// File: rtl/fp_cc_gen_chk.sv
module fp_cc_gen_chk (
  input logic        test_mode,
  input logic        dbl_sel,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic [1:0]  cc,
  input logic        invalid
);

  always_comb begin
    if (!$isunknown({test_mode, dbl_sel, opa, opb})) begin
      assert_test_no_invalid_R8: assert (!(test_mode && invalid))
        else $error("invalid raised in test mode");
      assert_invalid_unordered_R4: assert (!invalid || cc == 2'd3)
        else $error("invalid without unordered code");
      assert_test_nan_R5: assert (!(test_mode && dbl_sel && (&opa[62:52]) && (|opa[51:0])) || cc == 2'd3)
        else $error("binary64 NaN not classified as 3");
      assert_test_zero_R6: assert (!(test_mode && dbl_sel && opa[62:0] == 63'd0) || cc == 2'd0)
        else $error("binary64 zero not classified as 0");
    end
  end

endmodule

bind fp_cc_gen fp_cc_gen_chk chk (.*);

// File: tb/fp_cc_gen_test.sv
`timescale 1ns/1ps
module fp_cc_gen_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        test_mode, dbl_sel, invalid;
  logic [63:0] opa, opb;
  logic [1:0]  cc;

  fp_cc_gen uut (.test_mode(test_mode), .dbl_sel(dbl_sel), .opa(opa), .opb(opb),
                 .cc(cc), .invalid(invalid));

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic        t;
    logic        d;
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  cc;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 64'h3FF0000000000000, 64'h3FF0000000000000, 2'd0, 1'b0, 4'd1}, // R1
    '{1'b0, 1'b1, 64'h0000000000000000, 64'h8000000000000000, 2'd0, 1'b0, 4'd1}, // R1
    '{1'b0, 1'b0, 64'h0000000080000000, 64'h0000000000000000, 2'd0, 1'b0, 4'd1}, // R1
    '{1'b0, 1'b0, 64'h000000003F800000, 64'h0000000040000000, 2'd1, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b0, 64'h0000000040000000, 64'h000000003F800000, 2'd2, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b1, 64'hBFF0000000000000, 64'h3FF0000000000000, 2'd1, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b1, 64'hBFF0000000000000, 64'hC000000000000000, 2'd2, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b1, 64'hC000000000000000, 64'hBFF0000000000000, 2'd1, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b0, 64'h00000000FF800000, 64'h000000003F800000, 2'd1, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b1, 64'h0000000000000001, 64'h0000000000000000, 2'd2, 1'b0, 4'd2}, // R2
    '{1'b0, 1'b1, 64'h7FF8000000000000, 64'h3FF0000000000000, 2'd3, 1'b0, 4'd3}, // R3
    '{1'b0, 1'b0, 64'h000000007FC00000, 64'h000000007FC00000, 2'd3, 1'b0, 4'd3}, // R3
    '{1'b0, 1'b0, 64'h000000003F800000, 64'h000000007F800001, 2'd3, 1'b1, 4'd4}, // R4
    '{1'b0, 1'b1, 64'h7FF0000000000001, 64'h7FF8000000000000, 2'd3, 1'b1, 4'd4}, // R4
    '{1'b0, 1'b1, 64'hFFF8000000000000, 64'h0000000000000000, 2'd3, 1'b0, 4'd4}, // R4
    '{1'b1, 1'b0, 64'h000000007FC00000, 64'h0000000000000000, 2'd3, 1'b0, 4'd5}, // R5
    '{1'b1, 1'b1, 64'h7FF0000000000001, 64'h7FF0000000000001, 2'd3, 1'b0, 4'd5}, // R5
    '{1'b1, 1'b0, 64'h0000000080000000, 64'hFFFFFFFFFFFFFFFF, 2'd0, 1'b0, 4'd6}, // R6
    '{1'b1, 1'b1, 64'h0000000000000000, 64'h7FF0000000000001, 2'd0, 1'b0, 4'd6}, // R6
    '{1'b1, 1'b1, 64'hC000000000000000, 64'h0000000000000000, 2'd1, 1'b0, 4'd7}, // R7
    '{1'b1, 1'b1, 64'h8000000000000001, 64'h0000000000000000, 2'd1, 1'b0, 4'd7}, // R7
    '{1'b1, 1'b0, 64'h000000007F800000, 64'h0000000000000000, 2'd2, 1'b0, 4'd7}, // R7
    '{1'b1, 1'b0, 64'h000000003F800000, 64'h000000007F800001, 2'd2, 1'b0, 4'd8}, // R8
    '{1'b0, 1'b0, 64'hFFFFFFFF3F800000, 64'h000000003F800000, 2'd0, 1'b0, 4'd9}, // R9
    '{1'b1, 1'b0, 64'h7FF8000000000000, 64'h0000000000000000, 2'd0, 1'b0, 4'd9}, // R9
    '{1'b0, 1'b0, 64'h7FF0000140000000, 64'h123456783F800000, 2'd2, 1'b0, 4'd9}  // R9
  };

  task automatic check(input string tag, input logic [1:0] ecc, input logic einv);
    checks++;
    if (cc !== ecc || invalid !== einv) begin
      fails++;
      $display("FAIL %s: cc=%0d invalid=%0b expected cc=%0d invalid=%0b",
               tag, cc, invalid, ecc, einv);
    end
  endtask

  task automatic apply(input logic t, input logic d, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    #1;
    test_mode = t; dbl_sel = d; opa = a; opb = b;
    @(negedge clk);
  endtask

  initial begin
    test_mode = 1'b0; dbl_sel = 1'b0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset-time zero operands", 2'd0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].t, VEC[i].d, VEC[i].a, VEC[i].b);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].cc, VEC[i].inv);
    end

    // R8: opb changed while test mode holds opa fixed
    apply(1'b1, 1'b1, 64'h3FF0000000000000, 64'h7FF0000000000001);
    check("R8 test with sNaN opb", 2'd2, 1'b0);
    apply(1'b1, 1'b1, 64'h3FF0000000000000, 64'hFFF0000000000000);
    check("R8 test with -inf opb", 2'd2, 1'b0);

    // R9: binary32 sNaN in low half, binary64 reading of same bits is positive
    apply(1'b0, 1'b0, 64'h000000007F800001, 64'h0000000000000000);
    check("R9 binary32 sNaN low half", 2'd3, 1'b1);
    apply(1'b0, 1'b1, 64'h000000007F800001, 64'h0000000000000000);
    check("R9 same bits as binary64", 2'd2, 1'b0);

    // R2: largest finite against infinity
    apply(1'b0, 1'b1, 64'h7FEFFFFFFFFFFFFF, 64'h7FF0000000000000);
    check("R2 max finite below inf", 2'd1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule